// File: doc/BRIEF.md
# Eight-Channel Cycle-Stealing DMA Sequencer

The sequencer lets up to eight devices move single words to and from memory without running code. Once per processor cycle it runs a sync step: it samples the device request lines, picks the winner by fixed priority and asks the processor for a stolen cycle. The processor grants the request only when it is on the last cycle of an instruction. After a grant the sequencer holds the processor and runs four steps of equal length. In the first it selects the device and advances the channel's stored pointer. In the second it fetches the channel's end address. In the third it moves one word over the I/O bus. In the fourth it compares the pointer with the end address and arbitrates again.

Each channel's current pointer and end address live in two consecutive memory words at `BASE + 2*channel` and `BASE + 2*channel + 1`. Software stores the start address minus one in the pointer word, and the sequencer increments it before each use. When the updated pointer equals the end address, the channel gets an end-of-range pulse. A channel can also be set for block mode, which keeps the processor held between its words until the end of range is reached or the device raises the stop line.

One processor cycle, and so one step, is two clocks. Phase 0 is the first clock after reset. The memory port has a read latency of one clock.

Top module: `csdma_seq`

## Requirements
- R1: While reset is held and in the first clock after it, `steal_req_o`, `hold_o`, `dsel_o`, `erl_o`, `rrl_o`, `otp_o`, `mem_re_o` and `mem_we_o` are all 0.
- R2: Requests are sampled in phase 0 of a sync step. The lowest-numbered requesting channel wins, so channel 0 has the highest priority.
- R3: `steal_req_o` is high only in phase 1 of a sync step. If `grant_i` is low at that point, the selection is dropped and the next sync step arbitrates afresh, so a newer request with higher priority can win. A refused step writes no memory word.
- R4: A granted transfer runs the steps G, H, J and K, two clocks each, with `hold_o` high. `dsel_o` is one-hot for the channel being served, and the memory port never reads and writes in the same clock.
- R5: In step G the pointer word at `BASE+2c` is read, and the value plus one is written back. That new value is the data address used in step J.
- R6: In step J of an input channel (`dir_i[c]`=0), `io_din_i` is written to memory at the pointer while `rrl_o` pulses for one clock. `otp_o` stays low.
- R7: In step J of an output channel (`dir_i[c]`=1), the word at the pointer appears on `io_dout_o` in the same clock that `otp_o` and `rrl_o` both pulse.
- R8: If the updated pointer equals the end word, `erl_o` is high for one step after K while `dsel_o` still selects the channel. No request is taken, and the processor is then released.
- R9: If another channel requests at K, its transfer starts immediately and `hold_o` stays high. The channel just served is masked out of that arbitration.
- R10: Each time `hold_o` falls, it stays low for at least 4 clocks, because the first sync step after a release raises no request.
- R11: For a channel with `blk_en_i[c]`=1, `hold_o` stays high after K and sync steps repeat until a request arrives. Block mode ends at the end of range.
- R12: A high `stop_i` ends block mode, and a held sequencer with no pending request then releases the processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NCH | Device request lines |
| blk_en_i | input | NCH | Per-channel block-mode enable |
| dir_i | input | NCH | Per-channel direction, 1 = output to device |
| stop_i | input | 1 | Device stop, ends block mode |
| grant_i | input | 1 | Processor accepts the steal (last instruction cycle) |
| steal_req_o | output | 1 | Steal request to the processor |
| hold_o | output | 1 | Processor is held by the sequencer |
| dsel_o | output | NCH | One-hot device select |
| erl_o | output | 1 | End-of-range pulse |
| rrl_o | output | 1 | Reset-ready strobe |
| otp_o | output | 1 | Output data strobe |
| io_din_i | input | DW | I/O bus input data |
| io_dout_o | output | DW | I/O bus output data |
| mem_re_o | output | 1 | Memory read enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one clock after the read |

## Verification
Two events can meet in step K: the end-of-range check and a request from another channel that is already pending. The bench provokes this by raising channel 0 while channel 4 moves the last word of its range. It then requires a single `erl_o` pulse, a drop of `hold_o`, and exactly four low clocks before channel 0 is served. A refused steal can also coincide with a new request of higher priority. With `grant_i` held low, the bench raises channel 6 and then channel 1, and it checks that channel 1 is served first while channel 6's pointer word stays unchanged.

// File: rtl/csdma_pkg.sv
package csdma_pkg;
  // Sequencer steps; G/H/J/K form the stolen transfer
  typedef enum logic [2:0] {
    ST_SYNC,  // processor running, sync step arbitration
    ST_G,     // select device, advance pointer
    ST_H,     // fetch end word
    ST_J,     // one-word bus transfer
    ST_K,     // compare and re-arbitrate
    ST_EOR,   // end-of-range step, select held
    ST_HOLD   // block mode: processor held, sync steps repeat
  } step_e;
endpackage

// File: rtl/csdma_prio.sv
module csdma_prio #(
  parameter int NCH = 8,
  parameter int CW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic           hit,
  output logic [CW-1:0]  idx
);
  // lowest index wins: scan downwards so the last match is the smallest
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CW'(i);
    end
  end
endmodule

// File: rtl/csdma_memmux.sv
module csdma_memmux
  import csdma_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int BASE = 240,
  parameter int CW   = $clog2(NCH)
) (
  input  step_e          st,
  input  logic           ph,
  input  logic [CW-1:0]  ch,
  input  logic           dir_out,
  input  logic [AW-1:0]  ptr,
  input  logic [DW-1:0]  rdata,
  input  logic [DW-1:0]  din,
  output logic           re,
  output logic           we,
  output logic [AW-1:0]  addr,
  output logic [DW-1:0]  wdata,
  output logic [DW-1:0]  dout,
  output logic           rrl,
  output logic           otp
);
  logic [AW-1:0] slot;
  assign slot = AW'(BASE) + AW'({ch, 1'b0});

  always_comb begin
    re    = 1'b0;
    we    = 1'b0;
    addr  = slot;
    wdata = '0;
    dout  = '0;
    rrl   = 1'b0;
    otp   = 1'b0;
    case (st)
      ST_G: begin
        // phase 0 reads the pointer, phase 1 writes it back advanced
        if (!ph) re = 1'b1;
        else begin
          we    = 1'b1;
          wdata = rdata + DW'(1);
        end
      end
      ST_H: begin
        addr = slot + AW'(1);
        re   = !ph;
      end
      ST_J: begin
        addr = ptr;
        if (dir_out) begin
          re = !ph;
          if (ph) begin
            otp  = 1'b1;
            rrl  = 1'b1;
            dout = rdata;
          end
        end else if (ph) begin
          we    = 1'b1;
          wdata = din;
          rrl   = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/csdma_seq.sv
module csdma_seq
  import csdma_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int BASE = 240
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] blk_en_i,
  input  logic [NCH-1:0] dir_i,
  input  logic           stop_i,
  input  logic           grant_i,
  output logic           steal_req_o,
  output logic           hold_o,
  output logic [NCH-1:0] dsel_o,
  output logic           erl_o,
  output logic           rrl_o,
  output logic           otp_o,
  input  logic [DW-1:0]  io_din_i,
  output logic [DW-1:0]  io_dout_o,
  output logic           mem_re_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i
);
  localparam int CW = $clog2(NCH);

  step_e          st;
  logic           ph;
  logic           pend_v;
  logic [CW-1:0]  pend_ch;
  logic [CW-1:0]  ch_q;
  logic           dir_q;
  logic           blk_q;
  logic           cool_q;
  logic [DW-1:0]  ptr_q;
  logic [DW-1:0]  end_q;

  logic           sel_live;
  logic [NCH-1:0] sel_vec;
  logic [NCH-1:0] kmask;
  logic [NCH-1:0] avail;
  logic           win_v;
  logic [CW-1:0]  win_ch;

  assign sel_live = (st != ST_SYNC) && (st != ST_HOLD);

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign sel_vec[c] = sel_live && (ch_q == CW'(c));
    assign kmask[c]   = (st == ST_K) && (ch_q == CW'(c));
  end

  // served channel is masked at K; first sync step after a release is quiet
  assign avail = req_i & ~kmask & {NCH{!cool_q}};

  csdma_prio #(.NCH(NCH), .CW(CW)) u_prio (
    .req (avail),
    .hit (win_v),
    .idx (win_ch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_SYNC;
      ph      <= 1'b0;
      pend_v  <= 1'b0;
      pend_ch <= '0;
      ch_q    <= '0;
      dir_q   <= 1'b0;
      blk_q   <= 1'b0;
      cool_q  <= 1'b0;
      ptr_q   <= '0;
      end_q   <= '0;
    end else begin
      ph <= ~ph;
      case (st)
        ST_SYNC: begin
          if (!ph) begin
            pend_v  <= win_v;
            pend_ch <= win_ch;
          end else begin
            cool_q <= 1'b0;
            pend_v <= 1'b0;
            if (pend_v && grant_i) begin
              st    <= ST_G;
              ch_q  <= pend_ch;
              dir_q <= dir_i[pend_ch];
              blk_q <= blk_en_i[pend_ch];
            end
          end
        end
        ST_G: if (ph) begin
          ptr_q <= mem_rdata_i + DW'(1);
          st    <= ST_H;
        end
        ST_H: if (ph) begin
          end_q <= mem_rdata_i;
          st    <= ST_J;
        end
        ST_J: if (ph) st <= ST_K;
        ST_K: begin
          if (!ph) begin
            pend_v  <= win_v;
            pend_ch <= win_ch;
          end else begin
            pend_v <= 1'b0;
            if (ptr_q == end_q) begin
              st    <= ST_EOR;
              blk_q <= 1'b0;
            end else if (pend_v) begin
              st    <= ST_G;
              ch_q  <= pend_ch;
              dir_q <= dir_i[pend_ch];
              blk_q <= blk_en_i[pend_ch];
            end else if (blk_q && !stop_i) begin
              st <= ST_HOLD;
            end else begin
              st     <= ST_SYNC;
              cool_q <= 1'b1;
            end
          end
        end
        ST_EOR: if (ph) begin
          st     <= ST_SYNC;
          cool_q <= 1'b1;
        end
        ST_HOLD: begin
          if (!ph) begin
            pend_v  <= win_v;
            pend_ch <= win_ch;
          end else begin
            pend_v <= 1'b0;
            if (pend_v) begin
              st    <= ST_G;
              ch_q  <= pend_ch;
              dir_q <= dir_i[pend_ch];
              blk_q <= blk_en_i[pend_ch];
            end else if (!blk_q) begin
              st     <= ST_SYNC;
              cool_q <= 1'b1;
            end
          end
        end
        default: st <= ST_SYNC;
      endcase
      if (stop_i) blk_q <= 1'b0;
    end
  end

  csdma_memmux #(.NCH(NCH), .AW(AW), .DW(DW), .BASE(BASE), .CW(CW)) u_mux (
    .st      (st),
    .ph      (ph),
    .ch      (ch_q),
    .dir_out (dir_q),
    .ptr     (ptr_q[AW-1:0]),
    .rdata   (mem_rdata_i),
    .din     (io_din_i),
    .re      (mem_re_o),
    .we      (mem_we_o),
    .addr    (mem_addr_o),
    .wdata   (mem_wdata_o),
    .dout    (io_dout_o),
    .rrl     (rrl_o),
    .otp     (otp_o)
  );

  assign steal_req_o = (st == ST_SYNC) && pend_v;
  assign hold_o      = (st != ST_SYNC);
  assign dsel_o      = sel_vec;
  assign erl_o       = (st == ST_EOR);
endmodule

// File: rtl/csdma_chk.sv
module csdma_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           steal_req,
  input logic           grant,
  input logic           hold,
  input logic [NCH-1:0] dsel,
  input logic           erl,
  input logic           rrl,
  input logic           otp,
  input logic           mre,
  input logic           mwe
);
  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dsel));

  assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(mre && mwe));

  assert_sel_only_held_R4: assert property (@(posedge clk) disable iff (rst)
    (dsel != '0) |-> hold);

  assert_otp_with_rrl_R7: assert property (@(posedge clk) disable iff (rst)
    otp |-> rrl);

  assert_rrl_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
    rrl |-> (hold && dsel != '0));

  assert_erl_keeps_sel_R8: assert property (@(posedge clk) disable iff (rst)
    erl |-> (dsel != '0));

  assert_req_when_free_R3: assert property (@(posedge clk) disable iff (rst)
    steal_req |-> !hold);

  assert_hold_needs_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(steal_req && grant));

  assert_release_gap_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |=> (!hold ##1 !hold ##1 !hold));
endmodule

bind csdma_seq csdma_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .steal_req (steal_req_o),
  .grant     (grant_i),
  .hold      (hold_o),
  .dsel      (dsel_o),
  .erl       (erl_o),
  .rrl       (rrl_o),
  .otp       (otp_o),
  .mre       (mem_re_o),
  .mwe       (mem_we_o)
);

// File: tb/test_csdma_seq.sv
module test_csdma_seq;
  localparam int NCH = 8;
  localparam int AW  = 8;
  localparam int DW  = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] req;
  logic [NCH-1:0] kick = '0;
  logic [NCH-1:0] blk_en = 8'h80;
  logic [NCH-1:0] dir = 8'b1010_0000;
  logic           stop = 1'b0;
  logic           grant = 1'b1;
  logic [DW-1:0]  din = '0;

  logic           steal_req_o, hold_o, erl_o, rrl_o, otp_o;
  logic [NCH-1:0] dsel_o;
  logic [DW-1:0]  io_dout_o;
  logic           mem_re_o, mem_we_o;
  logic [AW-1:0]  mem_addr_o;
  logic [DW-1:0]  mem_wdata_o;
  logic [DW-1:0]  mem_rd;

  logic [DW-1:0]  mem [256];
  logic           tb_we = 1'b0;
  logic [AW-1:0]  tb_addr = '0;
  logic [DW-1:0]  tb_wd = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  csdma_seq #(.NCH(NCH), .AW(AW), .DW(DW), .BASE(240)) i_csdma_seq (
    .clk(clk), .rst(rst), .req_i(req), .blk_en_i(blk_en), .dir_i(dir),
    .stop_i(stop), .grant_i(grant), .steal_req_o(steal_req_o), .hold_o(hold_o),
    .dsel_o(dsel_o), .erl_o(erl_o), .rrl_o(rrl_o), .otp_o(otp_o),
    .io_din_i(din), .io_dout_o(io_dout_o), .mem_re_o(mem_re_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rd)
  );

  // memory model: one-clock read latency, bench setup port
  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (tb_we) mem[tb_addr] <= tb_wd;
    if (mem_re_o) mem_rd <= mem[mem_addr_o];
  end

  // device model: a request stays up until the device is selected
  always @(negedge clk) begin
    if (rst) req <= '0;
    else req <= (req | kick) & ~dsel_o;
  end

  // port monitor
  int n_rrl = 0, n_otp = 0, n_erl = 0, n_bad_strobe = 0, n_sreq = 0, n_drop = 0;
  int n_sel = 0, low_run = 0, last_gap = 0, high_run = 0, last_len = 0;
  int sel_log [64];
  logic [DW-1:0]  last_dout = '0;
  logic           erl_prev = 1'b0, hold_prev = 1'b0;
  logic [NCH-1:0] dsel_prev = '0;

  function automatic int oh2i(logic [NCH-1:0] v);
    for (int i = 0; i < NCH; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (rrl_o) n_rrl++;
      if (otp_o) begin n_otp++; last_dout = io_dout_o; end
      if (otp_o && !rrl_o) n_bad_strobe++;
      if (erl_o && dsel_o == '0) n_bad_strobe++;
      if (erl_o && !erl_prev) n_erl++;
      if (steal_req_o) n_sreq++;
      if (dsel_o != '0 && dsel_o != dsel_prev && n_sel < 64) begin
        sel_log[n_sel] = oh2i(dsel_o);
        n_sel++;
      end
      if (!hold_o) begin
        if (hold_prev) begin n_drop++; last_len = high_run; end
        low_run++;
        high_run = 0;
      end else begin
        if (!hold_prev) last_gap = low_run;
        low_run = 0;
        high_run++;
      end
      erl_prev  = erl_o;
      hold_prev = hold_o;
      dsel_prev = dsel_o;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(input int a, input int d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = AW'(a); tb_wd = DW'(d);
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic raise(input logic [NCH-1:0] m);
    @(posedge clk);
    #1 kick = m;
    @(negedge clk);
    #1 kick = '0;
  endtask

  task automatic t_reset;
    cyc(1);
    chk("R1 outputs idle", int'({steal_req_o, hold_o, erl_o, rrl_o, otp_o, mem_re_o, mem_we_o}), 0);
    chk("R1 select idle", int'(dsel_o), 0);
  endtask

  task automatic t_input;
    int r0, o0, e0, s0;
    poke(8'hF6, 16'h000F); poke(8'hF7, 16'h0012);
    din = 16'h1234;
    r0 = n_rrl; o0 = n_otp; e0 = n_erl; s0 = n_sel;
    raise(8'h08);
    cyc(30);
    chk("R6 data written at pointer", int'(mem[8'h10]), 16'h1234);
    chk("R5 pointer advanced", int'(mem[8'hF6]), 16'h0010);
    chk("R6 one reset-ready", n_rrl - r0, 1);
    chk("R6 no output strobe", n_otp - o0, 0);
    chk("R8 no end of range", n_erl - e0, 0);
    chk("R2 channel 3 selected", sel_log[s0], 3);
    chk("R4 four steps of two clocks", last_len, 8);
    din = 16'h4321;
    raise(8'h08);
    cyc(30);
    chk("R5 second word at next address", int'(mem[8'h11]), 16'h4321);
    chk("R5 pointer advanced again", int'(mem[8'hF6]), 16'h0011);
  endtask

  task automatic t_output;
    int r0, o0;
    poke(8'h40, 16'hBEEF); poke(8'hFA, 16'h003F); poke(8'hFB, 16'h0050);
    r0 = n_rrl; o0 = n_otp;
    raise(8'h20);
    cyc(30);
    chk("R7 one output strobe", n_otp - o0, 1);
    chk("R7 output data", int'(last_dout), 16'hBEEF);
    chk("R7 reset-ready with strobe", n_rrl - r0, 1);
    chk("R7 strobes coincide", n_bad_strobe, 0);
    chk("R5 output pointer advanced", int'(mem[8'hFA]), 16'h0040);
  endtask

  task automatic t_priority;
    int s0, d0;
    poke(8'hF4, 16'h001F); poke(8'hF5, 16'h0030);
    poke(8'hFC, 16'h002F); poke(8'hFD, 16'h003F);
    din = 16'h5555;
    s0 = n_sel; d0 = n_drop;
    raise(8'h44);
    cyc(40);
    chk("R2 channel 2 first", sel_log[s0], 2);
    chk("R9 channel 6 back-to-back", sel_log[s0 + 1], 6);
    chk("R9 hold kept between words", n_drop - d0, 1);
    chk("R9 both words stored", int'(mem[8'h20] == 16'h5555 && mem[8'h30] == 16'h5555), 1);
  endtask

  task automatic t_refuse;
    int q0, s0;
    poke(8'hF2, 16'h004F); poke(8'hF3, 16'h0060);
    grant = 1'b0;
    q0 = n_sreq; s0 = n_sel;
    raise(8'h40);
    cyc(10);
    chk("R3 request raised while refused", int'(n_sreq > q0), 1);
    chk("R3 processor not held", int'(hold_o), 0);
    chk("R3 pointer untouched when refused", int'(mem[8'hFC]), 16'h0030);
    raise(8'h02);
    cyc(6);
    grant = 1'b1;
    cyc(40);
    chk("R3 newer higher priority overtakes", sel_log[s0], 1);
    chk("R3 refused channel served later", sel_log[s0 + 1], 6);
  endtask

  task automatic t_eor;
    int e0, d0, s0;
    poke(8'hF8, 16'h006F); poke(8'hF9, 16'h0070);
    poke(8'hF0, 16'h007F); poke(8'hF1, 16'h0090);
    din = 16'h7777;
    e0 = n_erl; d0 = n_drop; s0 = n_sel;
    raise(8'h10);
    while (!hold_o) @(negedge clk);
    raise(8'h01);
    cyc(50);
    chk("R8 one end-of-range pulse", n_erl - e0, 1);
    chk("R8 select held during pulse", n_bad_strobe, 0);
    chk("R8 last word stored", int'(mem[8'h70]), 16'h7777);
    chk("R8 released before next channel", n_drop - d0, 2);
    chk("R10 four low clocks after release", last_gap, 4);
    chk("R8 pending channel served after", sel_log[s0 + 1], 0);
  endtask

  task automatic t_block;
    int d0, o0;
    poke(8'h90, 16'h0A0A); poke(8'h91, 16'h0B0B); poke(8'h92, 16'h0C0C);
    poke(8'hFE, 16'h008F); poke(8'hFF, 16'h00A0);
    d0 = n_drop; o0 = n_otp;
    raise(8'h80);
    cyc(30);
    chk("R11 held after block word", int'(hold_o), 1);
    chk("R11 no release in block mode", n_drop - d0, 0);
    chk("R11 first block word", int'(last_dout), 16'h0A0A);
    raise(8'h80);
    cyc(30);
    chk("R11 second block word", int'(last_dout), 16'h0B0B);
    chk("R11 still no release", n_drop - d0, 0);
    chk("R11 block pointer", int'(mem[8'hFE]), 16'h0091);
    chk("R11 two output strobes", n_otp - o0, 2);
    stop = 1'b1;
    cyc(2);
    stop = 1'b0;
    cyc(10);
    chk("R12 stop releases processor", int'(hold_o), 0);
    chk("R12 one release", n_drop - d0, 1);
  endtask

  task automatic t_block_eor;
    int e0;
    poke(8'hFF, 16'h0092);
    e0 = n_erl;
    raise(8'h80);
    cyc(40);
    chk("R11 block ends at end of range", n_erl - e0, 1);
    chk("R11 released after range", int'(hold_o), 0);
    chk("R11 last block word", int'(last_dout), 16'h0C0C);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 held in reset", int'({steal_req_o, hold_o, dsel_o != '0, erl_o, rrl_o, otp_o}), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_input();
    t_output();
    t_priority();
    t_refuse();
    t_eor();
    t_block();
    t_block_eor();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule